// File: doc/BRIEF.md
# Two-Dimensional Shifting Pixel Window

This block is a register array that holds a rectangular patch of reference pixels for a stencil datapath. It has a fixed number of rows, and each row is two load-widths wide. A single row load fills one half of the bottom row. That load can first push every row up by one, so the vertical window advances one line per fetched row. A rotate command turns every row left by one pixel, and the pixel that leaves column 0 re-enters at the far right.

A read port shows the leftmost columns of every row as a flat vector. A consumer sees one window position per rotate. After a full line of horizontal positions has been used, one shifted load prepares the window for the next output line. Nothing else has to be reloaded from memory. Instruction decode, memory access and the arithmetic on the window live outside this block.

Top module: `pshift_window`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stored pixel becomes zero, so `win_out` reads all zeros after that edge.
- R2: `win_out` always shows stored columns 0 to 15 of rows 0 to 15. Row 0 is the top row and row 15 the bottom row. Pixel (row r, column c) sits at bits `[(r*16+c)*10 +: 10]`.
- R3: A load with `load_shift` low writes load pixel j (bits `[j*10 +: 10]` of `load_data`) into bottom-row column `load_half*16 + j`. All other rows and the other half of the bottom row keep their values.
- R4: A load with `load_shift` high first moves each row r < 15 to take the old contents of row r+1. It then writes the new pixels into the selected half of row 15. The unselected half of row 15 keeps its old value.
- R5: A rotate with no load makes every row's column c take that row's old column (c+1) mod 32.
- R6: After 16 consecutive rotates the window shows the old columns 16 to 31. After 32 it shows the original columns 0 to 15 again.
- R7: When `load_en` and `rot_en` are high in the same cycle, only the load takes place and no row rotates.
- R8: With neither `load_en` nor `rot_en` high, all stored pixels hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Perform a row load this cycle |
| load_half | input | 1 | Target half of the bottom row: 0 = columns 0-15, 1 = columns 16-31 |
| load_shift | input | 1 | With a load: move all rows up by one first |
| load_data | input | 160 | Sixteen 10-bit pixels, pixel j at bits [j*10 +: 10] |
| rot_en | input | 1 | Rotate every row left by one pixel |
| win_out | output | 2560 | 16x16 window of 10-bit pixels, layout per R2 |

## Verification
A load and a rotate can both be requested in the same cycle. The bench raises them together with the shift flag both off and on and for both halves, in directed steps and throughout a long pseudo-random command sweep. After each such edge, the full window is compared with a bench model in which the load alone has taken effect. Any rotation that leaks through shows up as a pixel shifted by one column in rows that were not loaded.

// File: rtl/pwin_pkg.sv
// Package: shared command encoding for the shifting pixel window.
// Assumes: one command per cycle, already prioritised by the decoder.
package pwin_pkg;

    // Row-level command driven to every row slice in the same cycle.
    typedef enum logic [1:0] {
        OP_IDLE     = 2'd0,  // hold contents
        OP_ROT      = 2'd1,  // rotate left by one pixel
        OP_LD_KEEP  = 2'd2,  // load without vertical move
        OP_LD_SHIFT = 2'd3   // take row below, then load (bottom row)
    } win_op_e;

    // Width of a half-select field for a given number of halves.
    function automatic int sel_width(input int halves);
        return (halves > 1) ? $clog2(halves) : 1;
    endfunction

endpackage

// File: rtl/pwin_ctrl.sv
// Module: pwin_ctrl
// Turns the raw load/shift/rotate requests into a single row command.
// Assumes: a load always wins over a rotate requested in the same cycle.
module pwin_ctrl
    import pwin_pkg::*;
(
    input  logic    load_en,
    input  logic    load_shift,
    input  logic    rot_en,
    output win_op_e op
);

    // Purpose: priority decode, load ahead of rotate ahead of idle.
    always_comb begin
        if (load_en) begin
            op = load_shift ? OP_LD_SHIFT : OP_LD_KEEP;
        end else if (rot_en) begin
            op = OP_ROT;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/pwin_row.sv
// Module: pwin_row
// One row of the window: HALVES*HALF_PIX pixels of PIX_W bits each.
// Supports hold, rotate-left-by-one, taking the row below, and writing
// a load word into one half when wr_en is set (bottom row only).
// Assumes: below_q of the bottom row is tied to its own row_q.
module pwin_row
    import pwin_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int HALF_PIX = 16,
    parameter int HALVES   = 2,
    localparam int HALF_W  = HALF_PIX * PIX_W,
    localparam int ROW_W   = HALVES * HALF_W,
    localparam int SEL_W   = sel_width(HALVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_op_e           op,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  load_half,
    input  logic [HALF_W-1:0] load_data,
    input  logic [ROW_W-1:0]  below_q,
    output logic [ROW_W-1:0]  row_q
);

    logic [ROW_W-1:0] base;
    logic [ROW_W-1:0] nxt;

    // Purpose: choose the starting contents for this cycle's update.
    always_comb begin
        unique case (op)
            OP_ROT:      base = {row_q[PIX_W-1:0], row_q[ROW_W-1:PIX_W]};
            OP_LD_SHIFT: base = below_q;
            default:     base = row_q;
        endcase
    end

    // Purpose: overlay the load word onto the selected half when enabled.
    always_comb begin
        nxt = base;
        if (wr_en && (op == OP_LD_KEEP || op == OP_LD_SHIFT)) begin
            for (int h = 0; h < HALVES; h++) begin
                if (load_half == SEL_W'(h)) begin
                    nxt[h*HALF_W +: HALF_W] = load_data;
                end
            end
        end
    end

    // Purpose: row storage with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= nxt;
        end
    end

    // R1: reset clears the row
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (row_q == '0));

    // R5: rotate wraps column 0 to the far end and pulls column 1 down
    p_rotate_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROT) |=>
            (row_q[ROW_W-PIX_W +: PIX_W] == $past(row_q[0 +: PIX_W])) &&
            (row_q[0 +: PIX_W] == $past(row_q[PIX_W +: PIX_W])));

    // R4: a non-written row takes the row below on a shifted load
    p_shift_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LD_SHIFT && !wr_en) |=> (row_q == $past(below_q)));

    // R3: a non-written row holds on an unshifted load
    p_keep_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LD_KEEP && !wr_en) |=> $stable(row_q));

    // R3: the selected half holds the load word after a write
    p_half_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op != OP_IDLE && op != OP_ROT) |=>
            (row_q[$past(load_half)*HALF_W +: HALF_W] == $past(load_data)));

    // R8: idle holds the row
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> $stable(row_q));

endmodule

// File: rtl/pshift_window.sv
// Module: pshift_window
// Two-dimensional shifting pixel window. ROWS rows, each HALVES*HALF_PIX
// pixels wide. Row loads fill one half of the bottom row, optionally after
// an upward move of all rows; rotates turn every row left by one pixel.
// The read port exposes columns 0..WIN_COLS-1 of every row, row 0 first.
// Assumes: WIN_COLS <= HALVES*HALF_PIX and ROWS >= 2.
module pshift_window
    import pwin_pkg::*;
#(
    parameter int ROWS     = 16,
    parameter int PIX_W    = 10,
    parameter int HALF_PIX = 16,
    parameter int HALVES   = 2,
    parameter int WIN_COLS = 16,
    localparam int HALF_W    = HALF_PIX * PIX_W,
    localparam int ROW_W     = HALVES * HALF_W,
    localparam int WIN_ROW_W = WIN_COLS * PIX_W,
    localparam int WIN_W     = ROWS * WIN_ROW_W,
    localparam int SEL_W     = sel_width(HALVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [SEL_W-1:0]  load_half,
    input  logic              load_shift,
    input  logic [HALF_W-1:0] load_data,
    input  logic              rot_en,
    output logic [WIN_W-1:0]  win_out
);

    win_op_e          op;
    logic [ROW_W-1:0] rows [ROWS];

    pwin_ctrl u_ctrl (
        .load_en    (load_en),
        .load_shift (load_shift),
        .rot_en     (rot_en),
        .op         (op)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_W-1:0] below;
        logic             wr;

        // The bottom row feeds itself so a shifted load keeps its other half.
        if (r == ROWS - 1) begin : g_bottom
            assign below = rows[r];
            assign wr    = load_en;
        end else begin : g_inner
            assign below = rows[r+1];
            assign wr    = 1'b0;
        end

        pwin_row #(
            .PIX_W    (PIX_W),
            .HALF_PIX (HALF_PIX),
            .HALVES   (HALVES)
        ) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .op        (op),
            .wr_en     (wr),
            .load_half (load_half),
            .load_data (load_data),
            .below_q   (below),
            .row_q     (rows[r])
        );

        // Window tap at column offset zero.
        assign win_out[r*WIN_ROW_W +: WIN_ROW_W] = rows[r][WIN_ROW_W-1:0];
    end

    // R7: a load beside a rotate leaves the top row unrotated (unshifted load)
    p_load_beats_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && rot_en && !load_shift) |=> (rows[0] == $past(rows[0])));

    // R7: with a shifted load the top row is exactly the old second row
    p_shift_beats_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && rot_en && load_shift) |=> (rows[0] == $past(rows[1])));

endmodule

// File: tb/tb_pshift_window.sv
`timescale 1ns/1ps
module tb_pshift_window;

    localparam int NR = 16;
    localparam int NC = 32;
    localparam int WC = 16;
    localparam int PW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_en = 1'b0;
    logic [0:0]      load_half = 1'b0;
    logic            load_shift = 1'b0;
    logic [159:0]    load_data = '0;
    logic            rot_en = 1'b0;
    logic [2559:0]   win_out;

    int checks = 0;
    int failed = 0;
    bit done = 1'b0;

    logic [PW-1:0] mdl  [NR][NC];
    logic [PW-1:0] snap [NR][NC];
    logic [31:0]   lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    pshift_window dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_half(load_half),
        .load_shift(load_shift), .load_data(load_data), .rot_en(rot_en),
        .win_out(win_out)
    );

    function automatic logic [159:0] make_word(input int seed);
        logic [159:0] w;
        for (int j = 0; j < 16; j++) w[j*PW +: PW] = PW'((seed * 53 + j * 29 + 7) & 10'h3FF);
        return w;
    endfunction

    function automatic logic [PW-1:0] dut_pix(input int r, input int c);
        return win_out[(r*WC + c)*PW +: PW];
    endfunction

    // Model update per the requirements, applied at the same edge as the DUT.
    task automatic model_edge(input bit ld, input bit sh, input bit hf,
                              input logic [159:0] d, input bit rot);
        if (ld) begin
            if (sh) for (int r = 0; r < NR-1; r++)
                        for (int c = 0; c < NC; c++) mdl[r][c] = mdl[r+1][c];
            for (int j = 0; j < 16; j++) mdl[NR-1][hf*16 + j] = d[j*PW +: PW];
        end else if (rot) begin
            for (int r = 0; r < NR; r++) begin
                logic [PW-1:0] first;
                first = mdl[r][0];
                for (int c = 0; c < NC-1; c++) mdl[r][c] = mdl[r][c+1];
                mdl[r][NC-1] = first;
            end
        end
    endtask

    task automatic check_win(input string req);
        bit bad = 1'b0;
        checks++;
        for (int r = 0; r < NR && !bad; r++)
            for (int c = 0; c < WC && !bad; c++)
                if (dut_pix(r, c) !== mdl[r][c]) begin
                    bad = 1'b1;
                    failed++;
                    $display("FAIL %s row %0d col %0d actual %0d expected %0d",
                             req, r, c, dut_pix(r, c), mdl[r][c]);
                end
    endtask

    // Compare window against saved columns starting at col_base.
    task automatic check_snap(input string req, input int col_base);
        bit bad = 1'b0;
        checks++;
        for (int r = 0; r < NR && !bad; r++)
            for (int c = 0; c < WC && !bad; c++)
                if (dut_pix(r, c) !== snap[r][col_base + c]) begin
                    bad = 1'b1;
                    failed++;
                    $display("FAIL %s row %0d col %0d actual %0d expected %0d",
                             req, r, c, dut_pix(r, c), snap[r][col_base + c]);
                end
    endtask

    // One clock: drive at negedge, update model at posedge, check at negedge.
    task automatic step(input bit ld, input bit sh, input bit hf,
                        input logic [159:0] d, input bit rot, input string req);
        load_en = ld; load_shift = sh; load_half = hf; load_data = d; rot_en = rot;
        @(posedge clk);
        model_edge(ld, sh, hf, d, rot);
        @(negedge clk);
        load_en = 1'b0; rot_en = 1'b0; load_shift = 1'b0;
        check_win(req);
    endtask

    initial begin
        for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) mdl[r][c] = '0;
        // R1: reset with active commands must still clear
        load_en = 1'b1; rot_en = 1'b1; load_shift = 1'b1; load_data = make_word(99);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_win("R1");
        load_en = 1'b0; rot_en = 1'b0; load_shift = 1'b0;
        rst_n = 1'b1;

        // R4/R3: fill the array, left half with shift, right half in place
        for (int i = 0; i < NR; i++) begin
            step(1'b1, 1'b1, 1'b0, make_word(2*i), 1'b0, "R4");
            step(1'b1, 1'b0, 1'b1, make_word(2*i+1), 1'b0, "R3");
        end
        snap = mdl;

        // R5/R6: 16 rotates bring the right half into view
        for (int k = 0; k < 16; k++) step(1'b0, 1'b0, 1'b0, '0, 1'b1, "R5");
        @(negedge clk) check_snap("R6", 16);
        // R6: 16 more rotates restore the original view
        for (int k = 0; k < 16; k++) step(1'b0, 1'b0, 1'b0, '0, 1'b1, "R5");
        check_snap("R6", 0);

        // R4: advance one line; R8: idle holds
        step(1'b1, 1'b1, 1'b0, make_word(77), 1'b0, "R4");
        step(1'b1, 1'b0, 1'b1, make_word(78), 1'b0, "R3");
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, make_word(k), 1'b0, "R8");

        // R7: load and rotate together, every shift/half combination
        for (int m = 0; m < 4; m++) begin
            step(1'b0, 1'b0, 1'b0, '0, 1'b1, "R5");
            step(1'b1, m[0], m[1], make_word(100 + m), 1'b1, "R7");
        end

        // R2: pseudo-random command sweep, full window compared each cycle
        for (int n = 0; n < 600; n++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[0] & lfsr[1], lfsr[2], lfsr[3], make_word(int'(lfsr[15:4])),
                 lfsr[4] | lfsr[5], (lfsr[0] & lfsr[1] & (lfsr[4] | lfsr[5])) ? "R7" : "R2");
        end

        // R1: reset mid-run clears a populated array
        rst_n = 1'b0;
        @(posedge clk);
        for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) mdl[r][c] = '0;
        @(negedge clk);
        check_win("R1");
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, failed);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failed++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", checks, failed);
            $finish;
        end
    end

endmodule